// File: doc/BRIEF.md
# Selective Replay Slice Tracker

This block sits beside the rename stage of an out-of-order core that speculates on predicted values. It keeps a small table, indexed by destination tag, of poison vectors: one bit for each prediction slot that is still unverified. When an operation is renamed, its vector is built by OR-ing the vectors of its live source producers. If the operation makes a prediction of its own, it also receives a free prediction slot and sets that slot's bit in its own vector.

When a prediction is verified, the slot number arrives on the verify port. If the prediction was correct, the slot's bit is wiped from every vector at once and the slot is released. If it was wrong, every live entry that carries the bit is reported in a registered replay mask. Only the exact forward slice of the bad value is reported, not every younger operation. The slot's bit is then wiped and the slot released in the same way.

Retiring an entry removes it from the table.

Top module: `poison_replay_tracker`

## Requirements
- R1: After a synchronous reset, every table entry is dead, every prediction slot is free, `replay_mask` is zero, `ren_ready` is 1 and `ren_slot` is 0.
- R2: An accepted rename writes entry `ren_dst` (the tag is the table index) with the OR of the vectors of the enabled sources. A source whose tag names a dead entry contributes all zeros.
- R3: An accepted predicting rename takes the slot shown on `ren_slot`, which is always the lowest-numbered free slot. That slot's bit is set in the new entry's vector.
- R4: `ren_ready` is 0 exactly when all slots are busy. In that state a predicting rename is dropped and does not write its entry, while a non-predicting rename is still accepted.
- R5: A wrong verify of a busy slot S sets bit E of `replay_mask` in the next cycle for each entry E whose vector holds bit S. This includes an entry renamed in the same cycle, whose new vector is used. All other bits are 0.
- R6: Any verify of a busy slot removes that slot's bit from every vector, including a vector written by a same-cycle rename. The slot becomes free, and `ren_ready` and `ren_slot` reflect this from the next cycle.
- R7: A retire invalidates entry `ret_tag`. A dead entry, or an entry retiring in the same cycle as the broadcast, is never flagged. A rename to the same tag in that cycle takes precedence over the retire.
- R8: A verify that names a free slot changes nothing and flags nothing.
- R9: `replay_mask` is zero in every cycle that does not follow a wrong verify of a busy slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | Rename request |
| ren_dst | input | 3 | Destination tag (table entry) |
| ren_src_vld | input | 2 | Per-source enable |
| ren_src_tag | input | 6 | Source tags, source k at bits [3k+2:3k] |
| ren_predict | input | 1 | Renamed operation carries a prediction |
| ren_ready | output | 1 | At least one prediction slot is free |
| ren_slot | output | 2 | Slot a predicting rename receives this cycle |
| vfy_valid | input | 1 | Verification result present |
| vfy_slot | input | 2 | Slot being verified |
| vfy_wrong | input | 1 | 1 = prediction was wrong, 0 = correct |
| ret_valid | input | 1 | Retire request |
| ret_tag | input | 3 | Entry being retired |
| replay_mask | output | 8 | Entries that must re-execute, one cycle after a wrong verify |

## Verification
The assertions check the following on every cycle:
- a verified slot's bit is gone from every live vector afterwards;
- a retired entry is dead;
- allocation only ever takes a free slot, and slot occupancy does not move while all slots are full;
- the replay mask stays empty without a wrong broadcast and never names an entry that was not live.

The exact contents of the mask need the bench's scenarios. These include multi-level dependence chains, a slot reused after being freed, same-cycle rename with verify or retire, dropped renames while full, and a long pseudo-random run compared against a bench-side model.

// File: rtl/prt_pkg.sv
package prt_pkg;
  typedef enum logic {
    VFY_GOOD = 1'b0,
    VFY_BAD  = 1'b1
  } vfy_kind_e;
endpackage

// File: rtl/prt_slot_alloc.sv
module prt_slot_alloc #(
  parameter int SLOTS  = 4,
  parameter int SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_en,
  input  logic              free_en,
  input  logic [SLOT_W-1:0] free_idx,
  output logic              ready_q,
  output logic [SLOT_W-1:0] slot_q,
  output logic [SLOTS-1:0]  busy_q
);
  logic [SLOTS-1:0]  busy_d;
  logic [SLOT_W-1:0] pick_d;
  logic              found_d;

  always_comb begin
    busy_d = busy_q;
    if (alloc_en) busy_d[slot_q]   = 1'b1;
    if (free_en)  busy_d[free_idx] = 1'b0;
  end

  // lowest free slot of the next occupancy, so ready/slot leave a register
  always_comb begin
    pick_d  = '0;
    found_d = 1'b0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (!busy_d[s]) begin
        pick_d  = SLOT_W'(s);
        found_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= '0;
      ready_q <= 1'b1;
      slot_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      ready_q <= found_d;
      slot_q  <= pick_d;
    end
  end

  AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (rst)
    alloc_en |-> (ready_q && !busy_q[slot_q])); // R3
  AST_NO_ALLOC_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    (!ready_q && !free_en) |=> $stable(busy_q)); // R4
  AST_SLOT_FREED: assert property (@(posedge clk) disable iff (rst)
    free_en |=> !busy_q[$past(free_idx)]); // R6
endmodule

// File: rtl/prt_vec_table.sv
module prt_vec_table #(
  parameter int ENTRIES = 8,
  parameter int SLOTS   = 4,
  parameter int NSRC    = 2,
  parameter int TAG_W   = 3,
  parameter int SLOT_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [TAG_W-1:0]         wr_tag,
  input  logic [NSRC-1:0]          src_vld,
  input  logic [NSRC*TAG_W-1:0]    src_tag,
  input  logic                     own_en,
  input  logic [SLOT_W-1:0]        own_slot,
  input  logic                     clr_en,
  input  logic [SLOT_W-1:0]        clr_idx,
  input  logic                     ret_en,
  input  logic [TAG_W-1:0]         ret_tag,
  output logic [SLOTS-1:0]         new_vec,
  output logic [ENTRIES*SLOTS-1:0] vec_flat,
  output logic [ENTRIES-1:0]       live
);
  logic [SLOTS-1:0]   vec_q [ENTRIES];
  logic [ENTRIES-1:0] live_q;
  logic [SLOTS-1:0]   clr_mask;
  logic [SLOTS-1:0]   col_live;

  // union of live producers plus the operation's own slot
  always_comb begin
    new_vec = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (src_vld[s] && live_q[src_tag[s*TAG_W +: TAG_W]])
        new_vec = new_vec | vec_q[src_tag[s*TAG_W +: TAG_W]];
    end
    if (own_en) new_vec[own_slot] = 1'b1;
  end

  always_comb begin
    clr_mask = '0;
    if (clr_en) clr_mask[clr_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
      for (int e = 0; e < ENTRIES; e++) vec_q[e] <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (wr_en && wr_tag == TAG_W'(e)) begin
          live_q[e] <= 1'b1;
          vec_q[e]  <= new_vec & ~clr_mask;
        end else begin
          if (ret_en && ret_tag == TAG_W'(e)) live_q[e] <= 1'b0;
          vec_q[e] <= vec_q[e] & ~clr_mask;
        end
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_flat
      assign vec_flat[g*SLOTS +: SLOTS] = vec_q[g];
    end
  endgenerate
  assign live = live_q;

  always_comb begin
    col_live = '0;
    for (int e = 0; e < ENTRIES; e++)
      if (live_q[e]) col_live = col_live | vec_q[e];
  end

  AST_CLEAR_COLUMN: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> !col_live[$past(clr_idx)]); // R6
  AST_RETIRE_DROPS: assert property (@(posedge clk) disable iff (rst)
    (ret_en && !(wr_en && wr_tag == ret_tag)) |=> !live_q[$past(ret_tag)]); // R7
  AST_OWN_BIT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && own_en) |=> vec_q[$past(wr_tag)][$past(own_slot)]); // R3
endmodule

// File: rtl/prt_match.sv
module prt_match #(
  parameter int ENTRIES = 8,
  parameter int SLOTS   = 4,
  parameter int TAG_W   = 3,
  parameter int SLOT_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ENTRIES-1:0]       live,
  input  logic [ENTRIES*SLOTS-1:0] vec_flat,
  input  logic                     wr_en,
  input  logic [TAG_W-1:0]         wr_tag,
  input  logic [SLOTS-1:0]         new_vec,
  input  logic                     ret_en,
  input  logic [TAG_W-1:0]         ret_tag,
  input  logic                     bc_en,
  input  logic [SLOT_W-1:0]        bc_idx,
  output logic [ENTRIES-1:0]       replay_q
);
  logic [ENTRIES-1:0] hit;
  logic [ENTRIES-1:0] cand;

  // every entry compares against the broadcast slot in parallel
  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (wr_en && wr_tag == TAG_W'(e))
        hit[e] = new_vec[bc_idx];
      else
        hit[e] = live[e] && !(ret_en && ret_tag == TAG_W'(e))
                 && vec_flat[e*SLOTS + int'(bc_idx)];
    end
  end

  always_comb begin
    cand = live;
    if (ret_en) cand[ret_tag] = 1'b0;
    if (wr_en)  cand[wr_tag]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)        replay_q <= '0;
    else if (bc_en) replay_q <= hit;
    else            replay_q <= '0;
  end

  AST_QUIET_MASK: assert property (@(posedge clk) disable iff (rst)
    !bc_en |=> (replay_q == '0)); // R9
  AST_MASK_LIVE: assert property (@(posedge clk) disable iff (rst)
    bc_en |=> ((replay_q & ~$past(cand)) == '0)); // R5
endmodule

// File: rtl/poison_replay_tracker.sv
module poison_replay_tracker #(
  parameter int ENTRIES = 8,
  parameter int SLOTS   = 4,
  parameter int NSRC    = 2,
  localparam int TAG_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ren_valid,
  input  logic [TAG_W-1:0]      ren_dst,
  input  logic [NSRC-1:0]       ren_src_vld,
  input  logic [NSRC*TAG_W-1:0] ren_src_tag,
  input  logic                  ren_predict,
  output logic                  ren_ready,
  output logic [SLOT_W-1:0]     ren_slot,
  input  logic                  vfy_valid,
  input  logic [SLOT_W-1:0]     vfy_slot,
  input  logic                  vfy_wrong,
  input  logic                  ret_valid,
  input  logic [TAG_W-1:0]      ret_tag,
  output logic [ENTRIES-1:0]    replay_mask
);
  import prt_pkg::*;

  logic                     ren_acc;
  logic                     own_en;
  logic                     vfy_eff;
  logic                     bc_en;
  vfy_kind_e                vfy_kind;
  logic [SLOTS-1:0]         busy;
  logic [SLOTS-1:0]         new_vec;
  logic [ENTRIES*SLOTS-1:0] vec_flat;
  logic [ENTRIES-1:0]       live;

  assign vfy_kind = vfy_kind_e'(vfy_wrong);
  assign ren_acc  = ren_valid && (!ren_predict || ren_ready);
  assign own_en   = ren_acc && ren_predict;
  assign vfy_eff  = vfy_valid && busy[vfy_slot];
  assign bc_en    = vfy_eff && (vfy_kind == VFY_BAD);

  prt_slot_alloc #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_alloc (
    .clk      (clk),
    .rst      (rst),
    .alloc_en (own_en),
    .free_en  (vfy_eff),
    .free_idx (vfy_slot),
    .ready_q  (ren_ready),
    .slot_q   (ren_slot),
    .busy_q   (busy)
  );

  prt_vec_table #(
    .ENTRIES(ENTRIES), .SLOTS(SLOTS), .NSRC(NSRC), .TAG_W(TAG_W), .SLOT_W(SLOT_W)
  ) u_table (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (ren_acc),
    .wr_tag   (ren_dst),
    .src_vld  (ren_src_vld),
    .src_tag  (ren_src_tag),
    .own_en   (own_en),
    .own_slot (ren_slot),
    .clr_en   (vfy_eff),
    .clr_idx  (vfy_slot),
    .ret_en   (ret_valid),
    .ret_tag  (ret_tag),
    .new_vec  (new_vec),
    .vec_flat (vec_flat),
    .live     (live)
  );

  prt_match #(
    .ENTRIES(ENTRIES), .SLOTS(SLOTS), .TAG_W(TAG_W), .SLOT_W(SLOT_W)
  ) u_match (
    .clk      (clk),
    .rst      (rst),
    .live     (live),
    .vec_flat (vec_flat),
    .wr_en    (ren_acc),
    .wr_tag   (ren_dst),
    .new_vec  (new_vec),
    .ret_en   (ret_valid),
    .ret_tag  (ret_tag),
    .bc_en    (bc_en),
    .bc_idx   (vfy_slot),
    .replay_q (replay_mask)
  );

  AST_FREE_SLOT_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (vfy_valid && !busy[vfy_slot]) |=> (replay_mask == '0)); // R8
  AST_FULL_DROPS_PRED: assert property (@(posedge clk) disable iff (rst)
    (ren_valid && ren_predict && !ren_ready && !vfy_eff) |=> !ren_ready); // R4
endmodule

// File: tb/poison_replay_tracker_tb.sv
module poison_replay_tracker_tb;
  localparam int ENT = 8;
  localparam int SLT = 4;
  localparam int NS  = 2;
  localparam int TW  = 3;
  localparam int SW  = 2;

  logic clk = 1'b0;
  logic rst;
  logic ren_valid, ren_predict, vfy_valid, vfy_wrong, ret_valid, ren_ready;
  logic [TW-1:0] ren_dst, ret_tag;
  logic [NS-1:0] ren_src_vld;
  logic [NS*TW-1:0] ren_src_tag;
  logic [SW-1:0] ren_slot, vfy_slot;
  logic [ENT-1:0] replay_mask;

  int checks = 0;
  int errors = 0;

  logic [SLT-1:0] m_vec [ENT];
  logic [ENT-1:0] m_live;
  logic [SLT-1:0] m_busy;

  always #5 clk = ~clk;

  poison_replay_tracker u_dut (
    .clk(clk), .rst(rst), .ren_valid(ren_valid), .ren_dst(ren_dst),
    .ren_src_vld(ren_src_vld), .ren_src_tag(ren_src_tag), .ren_predict(ren_predict),
    .ren_ready(ren_ready), .ren_slot(ren_slot), .vfy_valid(vfy_valid),
    .vfy_slot(vfy_slot), .vfy_wrong(vfy_wrong), .ret_valid(ret_valid),
    .ret_tag(ret_tag), .replay_mask(replay_mask)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp,
                       input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic m_ready();
    return (m_busy != {SLT{1'b1}});
  endfunction

  function automatic int m_slot();
    for (int s = 0; s < SLT; s++) if (!m_busy[s]) return s;
    return 0;
  endfunction

  task automatic idle_inputs();
    ren_valid = 0; ren_dst = '0; ren_src_vld = '0; ren_src_tag = '0; ren_predict = 0;
    vfy_valid = 0; vfy_slot = '0; vfy_wrong = 0; ret_valid = 0; ret_tag = '0;
  endtask

  // one cycle: drive at negedge, predict from the requirements, check at next negedge
  task automatic step(input logic rv, input int dst, input logic [1:0] sv,
                      input int s0, input int s1, input logic pred,
                      input logic vv, input int vs, input logic vw,
                      input logic tv, input int tt, input string tag);
    logic acc, eff;
    logic [SLT-1:0] nv, clr;
    logic [ENT-1:0] exp_mask;
    int slot;
    ren_valid = rv; ren_dst = TW'(dst); ren_src_vld = sv;
    ren_src_tag = {TW'(s1), TW'(s0)}; ren_predict = pred;
    vfy_valid = vv; vfy_slot = SW'(vs); vfy_wrong = vw;
    ret_valid = tv; ret_tag = TW'(tt);
    slot = m_slot();
    acc = rv && (!pred || m_ready());
    nv = '0;
    if (sv[0] && m_live[s0]) nv = nv | m_vec[s0];
    if (sv[1] && m_live[s1]) nv = nv | m_vec[s1];
    if (acc && pred) nv[slot] = 1'b1;
    eff = vv && m_busy[vs];
    exp_mask = '0;
    if (eff && vw) begin
      for (int e = 0; e < ENT; e++) begin
        if (acc && dst == e) exp_mask[e] = nv[vs];
        else exp_mask[e] = m_live[e] && !(tv && tt == e) && m_vec[e][vs];
      end
    end
    clr = '0;
    if (eff) clr[vs] = 1'b1;
    for (int e = 0; e < ENT; e++) begin
      if (acc && dst == e) begin
        m_live[e] = 1'b1; m_vec[e] = nv & ~clr;
      end else begin
        if (tv && tt == e) m_live[e] = 1'b0;
        m_vec[e] = m_vec[e] & ~clr;
      end
    end
    if (acc && pred) m_busy[slot] = 1'b1;
    if (eff) m_busy[vs] = 1'b0;
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
    check(32'(replay_mask), 32'(exp_mask), tag, "replay_mask");
    check(32'(ren_ready), 32'(m_ready()), tag, "ren_ready");
    check(32'(ren_slot), 32'(m_slot()), tag, "ren_slot");
  endtask

  task automatic ren(input int dst, input logic [1:0] sv, input int s0, input int s1,
                     input logic pred, input string tag);
    step(1, dst, sv, s0, s1, pred, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic vfy(input int slot, input logic wrong, input string tag);
    step(0, 0, 2'b00, 0, 0, 0, 1, slot, wrong, 0, 0, tag);
  endtask

  task automatic retire(input int tag_e, input string tag);
    step(0, 0, 2'b00, 0, 0, 0, 0, 0, 0, 1, tag_e, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1'b1;
    m_live = '0; m_busy = '0;
    for (int e = 0; e < ENT; e++) m_vec[e] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(32'(replay_mask), 0, "R1", "replay_mask");
    check(32'(ren_ready), 1, "R1", "ren_ready");
    check(32'(ren_slot), 0, "R1", "ren_slot");

    // R2 R3 dependence chain: e0 predicts, e1<-e0, e2<-e1, e4 predicts, e5<-e2,e4
    ren(0, 2'b00, 0, 0, 1, "R3");
    ren(1, 2'b01, 0, 0, 0, "R2");
    ren(2, 2'b01, 1, 0, 0, "R2");
    ren(3, 2'b00, 0, 0, 0, "R2");
    ren(4, 2'b01, 3, 0, 1, "R3");
    check(32'(ren_slot), 2, "R3", "lowest free slot");
    ren(5, 2'b11, 2, 4, 0, "R2");
    vfy(0, 1, "R5");
    check(32'(replay_mask), 32'h27, "R5", "forward slice of slot0");
    // R6 correct verify clears the bit; slot reuse does not resurrect it
    vfy(1, 0, "R6");
    ren(6, 2'b00, 0, 0, 1, "R6");
    ren(7, 2'b00, 0, 0, 1, "R6");
    vfy(1, 1, "R6");
    check(32'(replay_mask), 32'h80, "R6", "reused slot flags only new owner");
    // R8 verify of a free slot
    vfy(2, 1, "R8");
    check(32'(replay_mask), 0, "R8", "free-slot broadcast");
    // R4 fill all slots
    ren(0, 2'b00, 0, 0, 1, "R4");
    ren(1, 2'b00, 0, 0, 1, "R4");
    ren(3, 2'b00, 0, 0, 1, "R4");
    check(32'(ren_ready), 0, "R4", "ready while full");
    retire(2, "R7");
    ren(2, 2'b01, 0, 0, 1, "R4");
    ren(4, 2'b01, 1, 0, 0, "R4");
    vfy(2, 1, "R4");
    vfy(3, 1, "R4");
    // R7 same-cycle retire and broadcast
    ren(5, 2'b01, 0, 0, 0, "R7");
    step(0, 0, 2'b00, 0, 0, 0, 1, 0, 1, 1, 5, "R7");
    // R5 rename consuming a slot in the same cycle it is reported wrong
    ren(4, 2'b00, 0, 0, 1, "R5");
    step(1, 5, 2'b01, 4, 0, 0, 1, m_slot() == 0 ? 0 : 0, 0, 0, 0, "R6");
    ren(4, 2'b00, 0, 0, 1, "R5");
    step(1, 5, 2'b01, 4, 0, 0, 1, 0, 1, 0, 0, "R5");
    // R2 dead source contributes nothing; R7 rename beats retire
    ren(3, 2'b01, 6, 0, 0, "R2");
    retire(3, "R2");
    ren(2, 2'b01, 3, 0, 0, "R2");
    step(1, 1, 2'b01, 6, 0, 0, 0, 0, 0, 1, 1, "R7");
    vfy(1, 1, "R7");
    vfy(0, 1, "R2");

    // near-exhaustive mixed traffic against the bench model
    for (int i = 0; i < 600; i++) begin
      step($urandom_range(0, 3) != 0, $urandom_range(0, ENT - 1), 2'($urandom_range(0, 3)),
           $urandom_range(0, ENT - 1), $urandom_range(0, ENT - 1), $urandom_range(0, 1) == 1,
           $urandom_range(0, 2) == 0, $urandom_range(0, SLT - 1), $urandom_range(0, 1) == 1,
           $urandom_range(0, 3) == 0, $urandom_range(0, ENT - 1), "R5");
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule